// File: doc/BRIEF.md
# Prioritized Interrupt Controller Core

This core collects eight interrupt request lines and presents one interrupt output to a processor. Each line passes through a mask. An unmasked line is captured into a pending register, either on a rising edge or while its level is high. A priority resolver chooses the most urgent pending line. It raises the interrupt output only when that line outranks every level already in service, so a nested handler is interrupted only by something more urgent.

The processor answers with two acknowledge pulses. The first pulse moves the winning level from pending to in-service. The second pulse produces an 8-bit vector: the upper five bits come from a programmed base and the lower three bits give the level number. In-service bits are released by end-of-interrupt command words, or at once when automatic release is enabled. The command words also rotate or set the priority order. The mask, sense mode, automatic release and vector base are plain inputs driven by a separate register block.

Top module: `irq_prio_ctrl`

## Requirements
- R1: When a line's mask bit is 1, that line never sets its pending bit and never causes the interrupt output to assert.
- R2: After reset the lowest-urgency level is 7, so level 0 is the most urgent and each higher number is less urgent.
- R3: The first acknowledge pulse sets the in-service bit of the winning level and clears its pending bit. The interrupt output goes low on the next clock edge.
- R4: One cycle after the second acknowledge pulse, vec_valid is high for exactly one cycle and vec_out equals {vec_base, level}, so base 00001 with level 3 gives 0x0B.
- R5: level_mode=0 captures a rising edge and holds it after the line falls. level_mode=1 makes the pending bit follow the unmasked line.
- R6: Command bits 7:5 = 001 clear the most urgent set in-service bit under the current order.
- R7: Command bits 7:5 = 011 clear only the in-service bit of the level in bits 2:0.
- R8: The interrupt output asserts only when the best pending level is more urgent than every in-service level.
- R9: With auto_eoi=1, the serviced level's in-service bit is clear by the time vec_valid is high.
- R10: Command bits 7:5 = 101 clear the most urgent in-service bit and make that level the lowest urgency. Bits 7:5 = 111 do the same for the level in bits 2:0.
- R11: Command bits 7:5 = 110 make the level in bits 2:0 the lowest urgency without touching in-service bits.
- R12: Command bits 7:5 = 100 turn on rotation at automatic release, and 000 turn it off. While it is on, a level released automatically becomes the lowest urgency.
- R13: If nothing is pending at the first acknowledge pulse, level 7 is serviced and its vector is returned.
- R14: After an in-service bit is released, the interrupt output asserts again for the next qualifying pending level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Request lines, one per level |
| irq_mask | input | 8 | Per-line mask, 1 blocks the line |
| level_mode | input | 1 | 1 level sensing, 0 edge sensing |
| auto_eoi | input | 1 | 1 releases in-service at the second acknowledge |
| vec_base | input | 5 | Upper bits of the returned vector |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 8 | End-of-interrupt / priority command |
| ack | input | 1 | Acknowledge pulse from the processor |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector returned after the second acknowledge |
| vec_valid | output | 1 | One-cycle strobe for vec_out |
| pending_o | output | 8 | Pending register contents |
| in_service_o | output | 8 | In-service register contents |

## Verification
A wrong rotation pointer cannot be seen directly. It shows up at the ports only the next time two levels compete: the wrong vector appears one cycle after the second acknowledge. The stimulus therefore follows every priority change with a contention between levels that the old order and the new order would resolve differently. A stale in-service bit suppresses int_out two cycles after the release command would have re-armed it. A leaked masked request shows in pending_o one cycle after the edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int CMD_W = 8;

  typedef enum logic [2:0] {
    OP_AEOI_ROT_OFF = 3'b000,
    OP_REL_TOP      = 3'b001,
    OP_NOP          = 3'b010,
    OP_REL_NAMED    = 3'b011,
    OP_AEOI_ROT_ON  = 3'b100,
    OP_ROT_REL_TOP  = 3'b101,
    OP_SET_LOWEST   = 3'b110,
    OP_ROT_REL_NAMED = 3'b111
  } cmd_op_e;

  typedef struct packed {
    logic clr_top;
    logic clr_named;
    logic rot_top;
    logic rot_named;
    logic set_low;
    logic aeoi_rot_on;
    logic aeoi_rot_off;
  } cmd_act_t;
endpackage

// File: rtl/irqc_cmd_dec.sv
module irqc_cmd_dec
  import irqc_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_word,
  output cmd_act_t         act,
  output logic [LVL_W-1:0] lvl
);
  cmd_op_e op;
  logic    unused_bits;

  assign op          = cmd_op_e'(cmd_word[CMD_W-1:CMD_W-3]);
  assign lvl         = cmd_word[LVL_W-1:0];
  assign unused_bits = ^cmd_word[CMD_W-4:LVL_W];

  always_comb begin
    act = '0;
    if (cmd_valid) begin
      case (op)
        OP_REL_TOP:       act.clr_top = 1'b1;
        OP_REL_NAMED:     act.clr_named = 1'b1;
        OP_ROT_REL_TOP:   begin act.clr_top = 1'b1; act.rot_top = 1'b1; end
        OP_ROT_REL_NAMED: begin act.clr_named = 1'b1; act.rot_named = 1'b1; end
        OP_SET_LOWEST:    act.set_low = 1'b1;
        OP_AEOI_ROT_ON:   act.aeoi_rot_on = 1'b1;
        OP_AEOI_ROT_OFF:  act.aeoi_rot_off = 1'b1;
        default:          act = '0;
      endcase
    end
  end
endmodule

// File: rtl/irqc_sense.sv
module irqc_sense #(
  parameter int NUM_LVL = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LVL-1:0] irq_in,
  input  logic [NUM_LVL-1:0] irq_mask,
  input  logic               level_mode,
  input  logic [NUM_LVL-1:0] take,
  output logic [NUM_LVL-1:0] req_q
);
  logic [NUM_LVL-1:0] irq_d;
  logic [NUM_LVL-1:0] rise;

  assign rise = irq_in & ~irq_d & ~irq_mask;

  always_ff @(posedge clk) begin
    if (rst) irq_d <= '0;
    else     irq_d <= irq_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= '0;
    end else begin
      for (int i = 0; i < NUM_LVL; i++) begin
        if (take[i])         req_q[i] <= 1'b0;
        else if (level_mode) req_q[i] <= irq_in[i] & ~irq_mask[i];
        else if (rise[i])    req_q[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int NUM_LVL = 8,
  parameter int LVL_W   = $clog2(NUM_LVL)
) (
  input  logic [NUM_LVL-1:0] pend,
  input  logic [NUM_LVL-1:0] svc,
  input  logic [LVL_W-1:0]   low_lvl,
  output logic               win_ok,
  output logic [LVL_W-1:0]   win_lvl,
  output logic               top_ok,
  output logic [LVL_W-1:0]   top_lvl,
  output logic               raise
);
  logic [LVL_W-1:0] win_rank;
  logic [LVL_W-1:0] top_rank;
  logic [LVL_W-1:0] idx;

  // rank 0 is the level just after the lowest-urgency one
  always_comb begin
    win_ok   = 1'b0;
    win_lvl  = '0;
    win_rank = '0;
    top_ok   = 1'b0;
    top_lvl  = '0;
    top_rank = '0;
    idx      = '0;
    for (int r = NUM_LVL - 1; r >= 0; r--) begin
      idx = low_lvl + LVL_W'(1) + LVL_W'(r);
      if (pend[idx]) begin
        win_ok   = 1'b1;
        win_lvl  = idx;
        win_rank = LVL_W'(r);
      end
      if (svc[idx]) begin
        top_ok   = 1'b1;
        top_lvl  = idx;
        top_rank = LVL_W'(r);
      end
    end
    raise = win_ok && (!top_ok || (win_rank < top_rank));
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter  int NUM_LVL = 8,
  parameter  int VEC_W   = 8,
  localparam int LVL_W   = $clog2(NUM_LVL),
  localparam int BASE_W  = VEC_W - LVL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LVL-1:0] irq_in,
  input  logic [NUM_LVL-1:0] irq_mask,
  input  logic               level_mode,
  input  logic               auto_eoi,
  input  logic [BASE_W-1:0]  vec_base,
  input  logic               cmd_valid,
  input  logic [CMD_W-1:0]   cmd_word,
  input  logic               ack,
  output logic               int_out,
  output logic [VEC_W-1:0]   vec_out,
  output logic               vec_valid,
  output logic [NUM_LVL-1:0] pending_o,
  output logic [NUM_LVL-1:0] in_service_o
);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(NUM_LVL - 1);

  logic [NUM_LVL-1:0] req_q, pend, take;
  logic [NUM_LVL-1:0] svc_q, svc_n;
  logic               phase2;
  logic [LVL_W-1:0]   sel_q, sel_now;
  logic [LVL_W-1:0]   low_q, low_n;
  logic               rot_aeoi_q;
  logic               ack1, ack2;
  logic               win_ok, top_ok, raise;
  logic [LVL_W-1:0]   win_lvl, top_lvl, cmd_lvl;
  cmd_act_t           act;

  assign ack1    = ack & ~phase2;
  assign ack2    = ack & phase2;
  assign pend    = req_q & ~irq_mask;
  assign sel_now = win_ok ? win_lvl : LAST_LVL;
  assign take    = ack1 ? (NUM_LVL'(1) << sel_now) : '0;

  irqc_sense #(.NUM_LVL(NUM_LVL)) u_sense (
    .clk(clk), .rst(rst), .irq_in(irq_in), .irq_mask(irq_mask),
    .level_mode(level_mode), .take(take), .req_q(req_q)
  );

  irqc_prio #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_prio (
    .pend(pend), .svc(svc_q), .low_lvl(low_q),
    .win_ok(win_ok), .win_lvl(win_lvl),
    .top_ok(top_ok), .top_lvl(top_lvl), .raise(raise)
  );

  irqc_cmd_dec #(.LVL_W(LVL_W)) u_dec (
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .act(act), .lvl(cmd_lvl)
  );

  always_comb begin
    svc_n = svc_q;
    if (ack1)             svc_n[sel_now] = 1'b1;
    if (ack2 && auto_eoi) svc_n[sel_q]   = 1'b0;
    if (act.clr_top && top_ok) svc_n[top_lvl] = 1'b0;
    if (act.clr_named)    svc_n[cmd_lvl] = 1'b0;
  end

  always_comb begin
    low_n = low_q;
    if (ack2 && auto_eoi && rot_aeoi_q) low_n = sel_q;
    if (act.rot_top && top_ok)          low_n = top_lvl;
    if (act.rot_named || act.set_low)   low_n = cmd_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      svc_q      <= '0;
      phase2     <= 1'b0;
      sel_q      <= '0;
      low_q      <= LAST_LVL;
      rot_aeoi_q <= 1'b0;
      int_out    <= 1'b0;
      vec_out    <= '0;
      vec_valid  <= 1'b0;
    end else begin
      svc_q     <= svc_n;
      low_q     <= low_n;
      vec_valid <= ack2;
      int_out   <= raise & ~phase2 & ~ack;
      if (act.aeoi_rot_on)       rot_aeoi_q <= 1'b1;
      else if (act.aeoi_rot_off) rot_aeoi_q <= 1'b0;
      if (ack1) begin
        phase2 <= 1'b1;
        sel_q  <= sel_now;
      end else if (ack2) begin
        phase2  <= 1'b0;
        vec_out <= {vec_base, sel_q};
      end
    end
  end

  assign pending_o    = req_q;
  assign in_service_o = svc_q;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter  int NUM_LVL = 8,
  parameter  int VEC_W   = 8,
  localparam int LVL_W   = $clog2(NUM_LVL),
  localparam int BASE_W  = VEC_W - LVL_W
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_LVL-1:0] irq_mask,
  input logic               auto_eoi,
  input logic [BASE_W-1:0]  vec_base,
  input logic               cmd_valid,
  input logic               ack,
  input logic               int_out,
  input logic [VEC_W-1:0]   vec_out,
  input logic               vec_valid,
  input logic [NUM_LVL-1:0] pending_o,
  input logic [NUM_LVL-1:0] in_service_o,
  input logic               phase2
);
  // R1
  masked_entry_chk: assert property (@(posedge clk) disable iff (rst)
    ((pending_o & ~$past(pending_o) & $past(irq_mask)) == '0));

  // R3
  first_ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !phase2) |=> (!int_out && phase2));

  // R4
  vec_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(ack && phase2));

  // R4
  vec_base_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (vec_out[VEC_W-1:LVL_W] == $past(vec_base)));

  // R9
  auto_release_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && $past(auto_eoi) && !$past(cmd_valid))
      |-> !in_service_o[vec_out[LVL_W-1:0]]);
endmodule

bind irq_prio_ctrl irqc_chk #(.NUM_LVL(NUM_LVL), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .irq_mask(irq_mask), .auto_eoi(auto_eoi),
  .vec_base(vec_base), .cmd_valid(cmd_valid), .ack(ack), .int_out(int_out),
  .vec_out(vec_out), .vec_valid(vec_valid), .pending_o(pending_o),
  .in_service_o(in_service_o), .phase2(phase2)
);

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] irq_in, irq_mask;
  logic       level_mode, auto_eoi;
  logic [4:0] vec_base;
  logic       cmd_valid;
  logic [7:0] cmd_word;
  logic       ack;
  logic       int_out, vec_valid;
  logic [7:0] vec_out, pending_o, in_service_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  logic [7:0] exp_q[$];

  always #2.5ns clk = ~clk;

  irq_prio_ctrl u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in), .irq_mask(irq_mask),
    .level_mode(level_mode), .auto_eoi(auto_eoi), .vec_base(vec_base),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .ack(ack),
    .int_out(int_out), .vec_out(vec_out), .vec_valid(vec_valid),
    .pending_o(pending_o), .in_service_o(in_service_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [7:0] m);
    irq_in = irq_in | m;
    tick(1);
    irq_in = irq_in & ~m;
  endtask

  task automatic cmd(input logic [7:0] w);
    cmd_word  = w;
    cmd_valid = 1'b1;
    tick(1);
    cmd_valid = 1'b0;
    tick(3);
  endtask

  task automatic ack_one();
    ack = 1'b1; tick(1); ack = 1'b0; tick(1);
  endtask

  // driver side of the scoreboard: push the vector the second pulse must yield
  task automatic ack_two(input logic [2:0] lvl);
    exp_q.push_back({vec_base, lvl});
    ack = 1'b1; tick(1); ack = 1'b0; tick(1);
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (!rst && vec_valid) begin
      if (exp_q.size() == 0) chk("R4 unexpected vector", {24'h0, vec_out}, 32'hFFFF_FFFF);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        chk("R4 vector", {24'h0, vec_out}, {24'h0, e});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; irq_in = '0; irq_mask = '0; level_mode = 1'b0; auto_eoi = 1'b0;
    vec_base = 5'b00001; cmd_valid = 1'b0; cmd_word = '0; ack = 1'b0;
    tick(3); rst = 1'b0; tick(2);
    chk("reset int", int_out, 0);
    chk("reset pending", pending_o, 0);
    chk("reset in-service", in_service_o, 0);
    chk("reset strobe", vec_valid, 0);

    // R1: masked edge is never captured, also not after unmasking
    irq_mask = 8'h08; pulse(8'h08); tick(3);
    chk("R1 pending", pending_o, 0);
    chk("R1 int", int_out, 0);
    irq_mask = 8'h00; tick(3);
    chk("R1 after unmask", pending_o, 0);

    // R2/R5: edges on 2 and 5 held; 2 wins
    pulse(8'h24); tick(3);
    chk("R5 edge held", pending_o, 8'h24);
    chk("R2 int", int_out, 1);
    ack_one();
    chk("R3 in-service", in_service_o, 8'h04);
    chk("R3 pending", pending_o, 8'h20);
    chk("R3 int low", int_out, 0);
    ack_two(3'd2); tick(3);
    chk("R8 blocked by 2", int_out, 0);

    // R6/R14
    cmd(8'h20);
    chk("R6 release", in_service_o, 8'h00);
    chk("R14 re-raise", int_out, 1);
    ack_one(); ack_two(3'd5); tick(1);
    chk("R3 second", in_service_o, 8'h20);

    // R8 nesting: level 1 outranks 5
    pulse(8'h02); tick(3);
    chk("R8 nested raise", int_out, 1);
    ack_one(); ack_two(3'd1); tick(1);
    cmd(8'h65);
    chk("R7 named release", in_service_o, 8'h02);
    cmd(8'h20);
    chk("R6 last release", in_service_o, 8'h00);

    // R5 level mode and R13 vanished request
    level_mode = 1'b1; irq_in[6] = 1'b1; tick(3);
    chk("R5 level pending", pending_o, 8'h40);
    chk("R5 level int", int_out, 1);
    irq_in[6] = 1'b0; tick(3);
    chk("R5 level follows", pending_o, 8'h00);
    chk("R5 level int low", int_out, 0);
    ack_one();
    chk("R13 default level", in_service_o, 8'h80);
    ack_two(3'd7); tick(1);
    cmd(8'h67);
    chk("R7 release 7", in_service_o, 8'h00);
    level_mode = 1'b0;

    // R9 automatic release
    auto_eoi = 1'b1; pulse(8'h08); tick(3);
    ack_one(); ack_two(3'd3); tick(2);
    chk("R9 auto release", in_service_o, 8'h00);

    // R12 rotation on automatic release
    cmd(8'h80);
    pulse(8'h04); tick(3);
    ack_one(); ack_two(3'd2); tick(2);
    pulse(8'h12); tick(3);
    ack_one(); ack_two(3'd4); tick(3);   // R12: 4 beats 1 after rotation
    ack_one(); ack_two(3'd1); tick(2);
    cmd(8'h00);
    auto_eoi = 1'b0;
    chk("R12 none left", in_service_o, 8'h00);

    // R11 set lowest = 3, then R10 rotate on named release
    cmd(8'hC3);
    pulse(8'h44); tick(3);
    ack_one();
    chk("R11 6 wins", in_service_o, 8'h40);
    ack_two(3'd6); tick(3);
    chk("R8 2 below 6", int_out, 0);
    cmd(8'hE6);
    chk("R10 named rotate", in_service_o, 8'h00);
    chk("R14 2 raised", int_out, 1);
    ack_one(); ack_two(3'd2); tick(1);
    chk("R10 serviced 2", in_service_o, 8'h04);

    // R10 rotate on top release: lowest becomes 2, so 3 beats 1
    cmd(8'hA0);
    chk("R10 top rotate", in_service_o, 8'h00);
    vec_base = 5'b01110;
    pulse(8'h0A); tick(3);
    ack_one(); ack_two(3'd3); tick(1);
    chk("R10 3 first", in_service_o, 8'h08);
    cmd(8'h20);
    chk("R14 1 next", int_out, 1);
    ack_one(); ack_two(3'd1); tick(1);
    cmd(8'h20);
    chk("R6 clear", in_service_o, 8'h00);
    chk("R3 pending empty", pending_o, 8'h00);
    cmd(8'hC7);

    tick(5);
    chk("R4 all vectors seen", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule